// File: doc/BRIEF.md
# Output Word Formatter with Parity

This block assembles the 20-bit word that a serial converter interface loads into its output shift register when a host frame begins. It keeps a copy of the most recent 16-bit two's-complement conversion result. On each frame-start strobe it registers a new word. The upper sixteen bits of that word come from one of three sources, in priority order: a pending register readback, a fixed test pattern, or the held conversion result.

The two bits below the data field can carry even-parity bits when parity is enabled. One parity bit covers the whole 16-bit field. The other covers a selectable number of its most significant bits. The two lowest bits are always zero. The word stays unchanged between frame starts, so the shifter downstream always sees a stable value for the whole frame.

Top module: `owf_word_fmt`

## Requirements
- R1: After reset, `word_o` is 0.
- R2: `word_o` takes a new value only on the clock edge that samples `frame_start_i` high, and is due one cycle after that sample. At every other cycle it holds its value.
- R3: If `rb_pend_i` is high when `frame_start_i` is sampled, then `word_o[19:12]` equals `rb_byte_i` and `word_o[11:0]` is 0. This holds whatever the pattern, parity and span settings are.
- R4: With no readback and `patn_sel_i[2]`=1, `word_o[19:4]` is 0000h for `patn_sel_i[1:0]`=00, FFFFh for 01, 5555h for 10 and 3333h for 11.
- R5: With no readback and `patn_sel_i[2]`=0, `word_o[19:4]` is the held conversion result.
- R6: The held result is loaded from `conv_data_i` on the edge that samples `conv_valid_i` high. A frame start sampled on that same edge still uses the previous result. A new result reaches `word_o` only at a later frame start.
- R7: Before any `conv_valid_i` after reset, the held result is 0.
- R8: With no readback and `par_en_i`=0, `word_o[3:2]` is 00.
- R9: With no readback and `par_en_i`=1, `word_o[3]` makes the count of ones in `word_o[19:3]` even.
- R10: With no readback and `par_en_i`=1, `word_o[2]` is the even parity of the top 4, 8, 12 or 16 bits of `word_o[19:4]`, for `par_span_i` = 00, 01, 10 and 11 respectively.
- R11: `word_o[1:0]` is always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle strobe at the start of a host frame |
| conv_valid_i | input | 1 | Strobe marking a new conversion result |
| conv_data_i | input | 16 | Conversion result, two's complement |
| rb_pend_i | input | 1 | A valid register read ran in the previous frame |
| rb_byte_i | input | 8 | Register byte to return |
| patn_sel_i | input | 3 | Pattern select: bit 2 enables a pattern, bits 1:0 choose it |
| par_en_i | input | 1 | Parity enable |
| par_span_i | input | 2 | Width code for the partial parity bit |
| word_o | output | 20 | Formatted output word |

## Verification
The bench drives every input on the falling clock edge. A frame start therefore meets exactly one rising edge, and `word_o` is read at the next falling edge, one cycle after the strobe. A conversion strobe likewise takes one edge to reach the held result. That result becomes visible only through the next frame start, so checks on it are made one frame later. Hold behaviour is checked by changing every control input and strobing new results with no frame start, then reading `word_o` several cycles later.

// File: rtl/owf_pkg.sv
package owf_pkg;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_SPANS = 4;

  typedef enum logic [1:0] {
    PAT_ZERO = 2'b00,
    PAT_ONES = 2'b01,
    PAT_ALT1 = 2'b10,
    PAT_ALT2 = 2'b11
  } pat_e;

  typedef enum logic [1:0] {
    SPAN_Q1   = 2'b00,
    SPAN_Q2   = 2'b01,
    SPAN_Q3   = 2'b10,
    SPAN_FULL = 2'b11
  } span_e;
endpackage

// File: rtl/owf_result_hold.sv
module owf_result_hold #(
  parameter int unsigned DATA_W = owf_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        result_q <= '0;
    else if (capture_i) result_q <= data_i;
  end

  assign result_o = result_q;

  p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> result_o == $past(data_i));
  p_hold_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(result_o));
endmodule

// File: rtl/owf_src_mux.sv
module owf_src_mux #(
  parameter int unsigned DATA_W = owf_pkg::DATA_W
) (
  input  logic              pat_en_i,
  input  owf_pkg::pat_e     pat_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] upper_o
);
  logic [DATA_W-1:0] alt1, alt2;

  // Alternating patterns built per bit position.
  for (genvar b = 0; b < DATA_W; b++) begin : g_pat
    assign alt1[b] = ((b % 2) == 0);
    assign alt2[b] = ((b % 4) < 2);
  end

  always_comb begin
    upper_o = result_i;
    if (pat_en_i) begin
      unique case (pat_i)
        owf_pkg::PAT_ZERO: upper_o = '0;
        owf_pkg::PAT_ONES: upper_o = '1;
        owf_pkg::PAT_ALT1: upper_o = alt1;
        owf_pkg::PAT_ALT2: upper_o = alt2;
        default:           upper_o = result_i;
      endcase
    end
  end
endmodule

// File: rtl/owf_parity.sv
module owf_parity #(
  parameter int unsigned DATA_W    = owf_pkg::DATA_W,
  parameter int unsigned NUM_SPANS = owf_pkg::NUM_SPANS
) (
  input  logic              en_i,
  input  owf_pkg::span_e    span_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [1:0]        par_o
);
  localparam int unsigned SPAN_W = DATA_W / NUM_SPANS;

  logic [NUM_SPANS-1:0] span_par;

  for (genvar s = 0; s < NUM_SPANS; s++) begin : g_span
    assign span_par[s] = ^data_i[DATA_W-1 -: SPAN_W*(s+1)];
  end

  always_comb begin
    par_o = 2'b00;
    if (en_i) par_o = {^data_i, span_par[span_i]};
  end
endmodule

// File: rtl/owf_word_fmt.sv
module owf_word_fmt #(
  parameter int unsigned DATA_W    = owf_pkg::DATA_W,
  parameter int unsigned REG_W     = owf_pkg::REG_W,
  parameter int unsigned NUM_SPANS = owf_pkg::NUM_SPANS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic                conv_valid_i,
  input  logic [DATA_W-1:0]   conv_data_i,
  input  logic                rb_pend_i,
  input  logic [REG_W-1:0]    rb_byte_i,
  input  logic [2:0]          patn_sel_i,
  input  logic                par_en_i,
  input  logic [1:0]          par_span_i,
  output logic [DATA_W+3:0]   word_o
);
  localparam int unsigned WORD_W = DATA_W + 4;
  localparam int unsigned RB_PAD = WORD_W - REG_W;

  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] upper;
  logic [1:0]        par;
  logic [WORD_W-1:0] word_q;
  owf_pkg::pat_e     pat;
  owf_pkg::span_e    span;

  assign pat  = owf_pkg::pat_e'(patn_sel_i[1:0]);
  assign span = owf_pkg::span_e'(par_span_i);

  owf_result_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (conv_valid_i),
    .data_i    (conv_data_i),
    .result_o  (result)
  );

  owf_src_mux #(.DATA_W(DATA_W)) u_mux (
    .pat_en_i (patn_sel_i[2]),
    .pat_i    (pat),
    .result_i (result),
    .upper_o  (upper)
  );

  owf_parity #(.DATA_W(DATA_W), .NUM_SPANS(NUM_SPANS)) u_par (
    .en_i   (par_en_i),
    .span_i (span),
    .data_i (upper),
    .par_o  (par)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (frame_start_i) begin
      if (rb_pend_i) word_q <= {rb_byte_i, {RB_PAD{1'b0}}};
      else           word_q <= {upper, par, 2'b00};
    end
  end

  assign word_o = word_q;

  p_hold_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(word_o));
  p_readback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && rb_pend_i |=>
      word_o == {$past(rb_byte_i), {RB_PAD{1'b0}}});
  p_par_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !rb_pend_i && !par_en_i |=> word_o[3:2] == 2'b00);
  p_par_even_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !rb_pend_i && par_en_i |=> !(^word_o[WORD_W-1:3]));
  p_result_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !rb_pend_i && !patn_sel_i[2] |=>
      word_o[WORD_W-1:4] == $past(result));
  p_low_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> word_o[1:0] == 2'b00);
endmodule

// File: tb/owf_word_fmt_tb_top.sv
module owf_word_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        conv_valid = 1'b0;
  logic [15:0] conv_data = '0;
  logic        rb_pend = 1'b0;
  logic [7:0]  rb_byte = '0;
  logic [2:0]  patn_sel = '0;
  logic        par_en = 1'b0;
  logic [1:0]  par_span = '0;
  logic [19:0] word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] model_res = '0;

  always #10 clk = ~clk;

  owf_word_fmt dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .frame_start_i (frame_start),
    .conv_valid_i  (conv_valid),
    .conv_data_i   (conv_data),
    .rb_pend_i     (rb_pend),
    .rb_byte_i     (rb_byte),
    .patn_sel_i    (patn_sel),
    .par_en_i      (par_en),
    .par_span_i    (par_span),
    .word_o        (word)
  );

  function automatic logic [19:0] exp_word(bit rb, logic [7:0] b, logic [2:0] p,
                                           bit pen, logic [1:0] sp, logic [15:0] res);
    logic [15:0] up;
    int ones_all, ones_top;
    if (rb) return {b, 12'h000};
    if (p[2]) begin
      case (p[1:0])
        2'd0: up = 16'h0000;
        2'd1: up = 16'hFFFF;
        2'd2: up = 16'h5555;
        default: up = 16'h3333;
      endcase
    end else up = res;
    ones_all = 0;
    ones_top = 0;
    for (int i = 0; i < 16; i++) begin
      if (up[i]) ones_all++;
      if (up[i] && i >= 16 - 4 * (int'(sp) + 1)) ones_top++;
    end
    if (!pen) return {up, 4'b0000};
    return {up, 1'(ones_all % 2), 1'(ones_top % 2), 2'b00};
  endfunction

  task automatic chk(string req, logic [19:0] act, logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: word_o=%05h expected %05h", req, act, exp);
    end
  endtask

  task automatic frame(bit rb, logic [7:0] b, logic [2:0] p, bit pen, logic [1:0] sp);
    rb_pend = rb; rb_byte = b; patn_sel = p; par_en = pen; par_span = sp;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic conv(logic [15:0] d);
    conv_valid = 1'b1; conv_data = d;
    @(negedge clk);
    conv_valid = 1'b0;
    model_res = d;
  endtask

  initial begin
    logic [15:0] vals [6];
    logic [19:0] held;
    vals = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h1234, 16'hA5C3};
    repeat (3) @(negedge clk);
    chk("R1 reset", word, 20'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", word, 20'h0);

    // R7: no conversion yet, result source reads zero.
    for (int pen = 0; pen < 2; pen++) begin
      frame(0, 8'h00, 3'b000, 1'(pen), 2'b11);
      chk("R7 empty result", word, exp_word(0, 0, 3'b000, 1'(pen), 2'b11, 16'h0));
    end

    // R4 R5 R8 R9 R10 R11: sweep result, pattern, parity and span.
    foreach (vals[v]) begin
      conv(vals[v]);
      for (int p = 0; p < 8; p++)
        for (int pen = 0; pen < 2; pen++)
          for (int sp = 0; sp < 4; sp++) begin
            frame(0, 8'hFF, 3'(p), 1'(pen), 2'(sp));
            chk(p[2] ? "R4 pattern" : (pen ? "R9 R10 parity" : "R5 R8 result"), word,
                exp_word(0, 8'hFF, 3'(p), 1'(pen), 2'(sp), model_res));
          end
    end

    // R3: readback of every byte over assorted settings.
    for (int b = 0; b < 256; b++) begin
      frame(1, 8'(b), 3'(b % 8), 1'(b % 2), 2'(b / 8));
      chk("R3 readback", word, exp_word(1, 8'(b), 3'(b % 8), 1'(b % 2), 2'(b / 8), model_res));
    end

    // R2 R6: new result and new settings without a frame start leave word unchanged.
    frame(0, 8'h00, 3'b000, 1'b1, 2'b01);
    held = word;
    chk("R5 result", held, exp_word(0, 0, 3'b000, 1, 2'b01, model_res));
    rb_pend = 1'b1; rb_byte = 8'h5A; patn_sel = 3'b101; par_en = 1'b0;
    conv(16'h0F0E);
    repeat (4) @(negedge clk);
    chk("R2 hold", word, held);
    chk("R6 not yet loaded", word, held);
    frame(0, 8'h00, 3'b000, 1'b1, 2'b01);
    chk("R6 loaded at frame", word, exp_word(0, 0, 3'b000, 1, 2'b01, 16'h0F0E));

    // R6: conversion strobe on the same edge as frame start uses the old result.
    conv_valid = 1'b1; conv_data = 16'hC001;
    frame(0, 8'h00, 3'b000, 1'b0, 2'b00);
    conv_valid = 1'b0;
    chk("R6 same edge old", word, exp_word(0, 0, 3'b000, 0, 2'b00, 16'h0F0E));
    model_res = 16'hC001;
    frame(0, 8'h00, 3'b000, 1'b0, 2'b00);
    chk("R6 next frame new", word, exp_word(0, 0, 3'b000, 0, 2'b00, 16'hC001));
    chk("R11 low bits", {18'h0, word[1:0]}, 20'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: expected end, got timeout");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule